// File: doc/BRIEF.md
# Set Combiner with Sequential Cardinality

This block forms one set from two operand sets over a universe of `UNIVERSE` elements. A build-time parameter picks union, intersection or difference. Each operand is an external set store with two query ports. A query port gives membership for any index. A scan port gives membership for an index that this block drives. Each port returns a membership bit and a valid bit.

Membership of the result comes straight from the operands' query answers through logic only, so a caller can probe any element at any time. The size of the result is found by a scan. After an execute command, an index walks from 0 to `UNIVERSE-1`. At each index where both operands report valid data, the running count increases by one if that element belongs to the result. Each element is visited exactly once, so an element that is in both operands of a union is counted once. When the walk ends, a cardinality-valid flag rises and the count holds until the next init.

Top module: `set_combine_card`

## Requirements
- R1: With `OP_KIND` = union, `res_mem_o` equals `a_q_mem_i | b_q_mem_i` at every query index.
- R2: With `OP_KIND` = intersection, `res_mem_o` equals `a_q_mem_i & b_q_mem_i`.
- R3: With `OP_KIND` = difference, `res_mem_o` equals `a_q_mem_i & ~b_q_mem_i`.
- R4: `res_mem_vld_o` is 0 after reset and after init. From the clock edge that samples `exec_i` onward, it equals `a_q_vld_i & b_q_vld_i`.
- R5: When the scan ends, `card_o` equals the number of indexes 0..UNIVERSE-1 whose result membership is 1. The count ranges from 0 to UNIVERSE inclusive and is `$clog2(UNIVERSE+1)` bits wide.
- R6: In a cycle of the scan where `a_s_vld_i` or `b_s_vld_i` is 0, neither `scan_idx_o` nor `card_o` changes.
- R7: With the scan valids held high, `card_vld_o` rises exactly UNIVERSE clock edges after the edge that samples `exec_i` in idle.
- R8: Once `card_vld_o` is 1, it and `card_o` hold, and a further `exec_i` has no effect. `init_i` returns the block to idle with `card_o`=0, `card_vld_o`=0 and `scan_idx_o`=0. If `init_i` and `exec_i` are high together, `init_i` wins.
- R9: After reset, `card_o`=0, `card_vld_o`=0, `res_mem_vld_o`=0 and `scan_idx_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Return to idle and clear the count |
| exec_i | input | 1 | Start the cardinality scan when idle |
| a_q_mem_i | input | 1 | Operand A membership at the caller's query index |
| a_q_vld_i | input | 1 | Operand A query answer valid |
| b_q_mem_i | input | 1 | Operand B membership at the caller's query index |
| b_q_vld_i | input | 1 | Operand B query answer valid |
| scan_idx_o | output | $clog2(UNIVERSE) | Index presented to both operands' scan ports |
| a_s_mem_i | input | 1 | Operand A membership at `scan_idx_o` |
| a_s_vld_i | input | 1 | Operand A scan answer valid |
| b_s_mem_i | input | 1 | Operand B membership at `scan_idx_o` |
| b_s_vld_i | input | 1 | Operand B scan answer valid |
| res_mem_o | output | 1 | Result membership at the query index |
| res_mem_vld_o | output | 1 | Result membership valid |
| card_o | output | $clog2(UNIVERSE+1) | Running and final cardinality |
| card_vld_o | output | 1 | Cardinality complete |

## Verification
The assertions assume that the operand scan ports answer for the index currently on `scan_idx_o` in the same cycle. They also assume that a stalled operand can hold its valid low for any number of cycles without the block losing its place. In the bench, the operand stores are plain bit vectors indexed directly by the block's scan index. All inputs change on the falling clock edge. Valid bits are dropped only for bounded windows in the middle of a scan, so every scan finishes and the count can never go above UNIVERSE.

// File: rtl/set_card_pkg.sv
package set_card_pkg;

   typedef enum logic [1:0] {
      OP_UNION = 2'd0,
      OP_INTER = 2'd1,
      OP_DIFF  = 2'd2
   } set_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_DONE = 2'd2
   } scan_state_e;

endpackage

// File: rtl/set_op_combine.sv
module set_op_combine
   import set_card_pkg::*;
#(
   parameter set_op_e OP_KIND = OP_UNION
) (
   input  logic a_mem_i,
   input  logic a_vld_i,
   input  logic b_mem_i,
   input  logic b_vld_i,
   output logic res_mem_o,
   output logic res_vld_o
);

   generate
      if (OP_KIND == OP_UNION) begin : g_union
         assign res_mem_o = a_mem_i | b_mem_i;
      end else if (OP_KIND == OP_INTER) begin : g_inter
         assign res_mem_o = a_mem_i & b_mem_i;
      end else if (OP_KIND == OP_DIFF) begin : g_diff
         assign res_mem_o = a_mem_i & ~b_mem_i;
      end else begin : g_bad_op
         $error("set_op_combine: unsupported OP_KIND");
         assign res_mem_o = 1'b0;
      end
   endgenerate

   assign res_vld_o = a_vld_i & b_vld_i;

endmodule

// File: rtl/scan_index_ctr.sv
module scan_index_ctr #(
   parameter int UNIVERSE = 8,
   localparam int IDXW = (UNIVERSE > 1) ? $clog2(UNIVERSE) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr_i,
   input  logic            adv_i,
   output logic [IDXW-1:0] idx_o,
   output logic            last_o
);

   localparam logic [IDXW-1:0] LAST_IDX = IDXW'(UNIVERSE - 1);

   logic [IDXW-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (clr_i) begin
         idx_q <= '0;
      end else if (adv_i) begin
         idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
      end
   end

   assign idx_o  = idx_q;
   assign last_o = (idx_q == LAST_IDX);

   AST_IDX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !clr_i) |=> $stable(idx_o)) else $error("index moved while stalled"); // R6

   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      idx_o <= LAST_IDX) else $error("index beyond universe"); // R5

endmodule

// File: rtl/card_accum.sv
module card_accum #(
   parameter int UNIVERSE = 8,
   localparam int CW = $clog2(UNIVERSE + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          inc_i,
   output logic [CW-1:0] cnt_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o <= CW'(UNIVERSE)) else $error("count above universe size"); // R5

   AST_CNT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !clr_i) |=> $stable(cnt_o)) else $error("count moved without increment"); // R6

endmodule

// File: rtl/set_combine_card.sv
module set_combine_card
   import set_card_pkg::*;
#(
   parameter int      UNIVERSE = 8,
   parameter set_op_e OP_KIND  = OP_UNION,
   localparam int IDXW = (UNIVERSE > 1) ? $clog2(UNIVERSE) : 1,
   localparam int CW   = $clog2(UNIVERSE + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            init_i,
   input  logic            exec_i,
   input  logic            a_q_mem_i,
   input  logic            a_q_vld_i,
   input  logic            b_q_mem_i,
   input  logic            b_q_vld_i,
   output logic [IDXW-1:0] scan_idx_o,
   input  logic            a_s_mem_i,
   input  logic            a_s_vld_i,
   input  logic            b_s_mem_i,
   input  logic            b_s_vld_i,
   output logic            res_mem_o,
   output logic            res_mem_vld_o,
   output logic [CW-1:0]   card_o,
   output logic            card_vld_o
);

   generate
      if (UNIVERSE < 2) begin : g_bad_universe
         $error("set_combine_card: UNIVERSE must be at least 2");
      end
   endgenerate

   scan_state_e state_q, state_d;
   logic        q_res_mem, q_res_vld;
   logic        s_res_mem, s_res_vld;
   logic        start, step, clr, idx_last;

   // Query path: caller's index, pure logic.
   set_op_combine #(.OP_KIND(OP_KIND)) u_query_op (
      .a_mem_i   (a_q_mem_i),
      .a_vld_i   (a_q_vld_i),
      .b_mem_i   (b_q_mem_i),
      .b_vld_i   (b_q_vld_i),
      .res_mem_o (q_res_mem),
      .res_vld_o (q_res_vld)
   );

   // Scan path: block's own index.
   set_op_combine #(.OP_KIND(OP_KIND)) u_scan_op (
      .a_mem_i   (a_s_mem_i),
      .a_vld_i   (a_s_vld_i),
      .b_mem_i   (b_s_mem_i),
      .b_vld_i   (b_s_vld_i),
      .res_mem_o (s_res_mem),
      .res_vld_o (s_res_vld)
   );

   assign start = (state_q == ST_IDLE) && exec_i && !init_i;
   assign clr   = init_i || start;
   assign step  = (state_q == ST_SCAN) && s_res_vld && !init_i;

   always_comb begin
      state_d = state_q;
      if (init_i) begin
         state_d = ST_IDLE;
      end else begin
         unique case (state_q)
            ST_IDLE: if (exec_i) state_d = ST_SCAN;
            ST_SCAN: if (step && idx_last) state_d = ST_DONE;
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   scan_index_ctr #(.UNIVERSE(UNIVERSE)) u_idx (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (clr),
      .adv_i  (step),
      .idx_o  (scan_idx_o),
      .last_o (idx_last)
   );

   card_accum #(.UNIVERSE(UNIVERSE)) u_card (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr),
      .inc_i (step && s_res_mem),
      .cnt_o (card_o)
   );

   assign res_mem_o     = q_res_mem;
   assign res_mem_vld_o = (state_q != ST_IDLE) && q_res_vld;
   assign card_vld_o    = (state_q == ST_DONE);

   AST_MEM_VLD_NEEDS_OPS: assert property (@(posedge clk) disable iff (!rst_n)
      res_mem_vld_o |-> (a_q_vld_i && b_q_vld_i)) else $error("membership valid without operands"); // R4

   AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (card_vld_o && !init_i) |=> (card_vld_o && $stable(card_o))) else $error("result not held"); // R8

   AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> (!card_vld_o && card_o == '0 && scan_idx_o == '0)) else $error("init did not clear"); // R8

   generate
      if (OP_KIND == OP_UNION) begin : g_chk_union
         AST_UNION_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
            (a_q_mem_i || b_q_mem_i) |-> res_mem_o) else $error("union lost a member"); // R1
      end else if (OP_KIND == OP_INTER) begin : g_chk_inter
         AST_INTER_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
            res_mem_o |-> (a_q_mem_i && b_q_mem_i)) else $error("intersection extra member"); // R2
      end else begin : g_chk_diff
         AST_DIFF_EXCLUDES: assert property (@(posedge clk) disable iff (!rst_n)
            res_mem_o |-> (a_q_mem_i && !b_q_mem_i)) else $error("difference extra member"); // R3
      end
   endgenerate

endmodule

// File: tb/set_combine_card_tb.sv
module set_combine_card_tb;
   import set_card_pkg::*;

   localparam int N    = 8;
   localparam int IDXW = $clog2(N);
   localparam int CW   = $clog2(N + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic init_i = 1'b0, exec_i = 1'b0;
   logic [N-1:0] set_a = '0, set_b = '0;
   logic [IDXW-1:0] qidx = '0;
   logic a_qv = 1'b1, b_qv = 1'b1, a_sv = 1'b1, b_sv = 1'b1;

   logic [IDXW-1:0] sidx_u, sidx_i, sidx_d;
   logic mem_u, mem_i, mem_d, mv_u, mv_i, mv_d, cv_u, cv_i, cv_d;
   logic [CW-1:0] card_u, card_i, card_d;

   int checks = 0;
   int failures = 0;

   set_combine_card #(.UNIVERSE(N), .OP_KIND(OP_UNION)) u_dut (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .exec_i(exec_i),
      .a_q_mem_i(set_a[qidx]), .a_q_vld_i(a_qv), .b_q_mem_i(set_b[qidx]), .b_q_vld_i(b_qv),
      .scan_idx_o(sidx_u),
      .a_s_mem_i(set_a[sidx_u]), .a_s_vld_i(a_sv), .b_s_mem_i(set_b[sidx_u]), .b_s_vld_i(b_sv),
      .res_mem_o(mem_u), .res_mem_vld_o(mv_u), .card_o(card_u), .card_vld_o(cv_u));

   set_combine_card #(.UNIVERSE(N), .OP_KIND(OP_INTER)) u_dut_inter (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .exec_i(exec_i),
      .a_q_mem_i(set_a[qidx]), .a_q_vld_i(a_qv), .b_q_mem_i(set_b[qidx]), .b_q_vld_i(b_qv),
      .scan_idx_o(sidx_i),
      .a_s_mem_i(set_a[sidx_i]), .a_s_vld_i(a_sv), .b_s_mem_i(set_b[sidx_i]), .b_s_vld_i(b_sv),
      .res_mem_o(mem_i), .res_mem_vld_o(mv_i), .card_o(card_i), .card_vld_o(cv_i));

   set_combine_card #(.UNIVERSE(N), .OP_KIND(OP_DIFF)) u_dut_diff (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .exec_i(exec_i),
      .a_q_mem_i(set_a[qidx]), .a_q_vld_i(a_qv), .b_q_mem_i(set_b[qidx]), .b_q_vld_i(b_qv),
      .scan_idx_o(sidx_d),
      .a_s_mem_i(set_a[sidx_d]), .a_s_vld_i(a_sv), .b_s_mem_i(set_b[sidx_d]), .b_s_vld_i(b_sv),
      .res_mem_o(mem_d), .res_mem_vld_o(mv_d), .card_o(card_d), .card_vld_o(cv_d));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int pop(input logic [N-1:0] v);
      int c = 0;
      for (int i = 0; i < N; i++) c += int'(v[i]);
      return c;
   endfunction

   task automatic pulse_init();
      init_i = 1'b1;
      @(negedge clk);
      init_i = 1'b0;
   endtask

   task automatic pulse_exec();
      exec_i = 1'b1;
      @(negedge clk);
      exec_i = 1'b0;
   endtask

   task automatic t_reset();
      check("R9 card_o", int'(card_u), 0);
      check("R9 card_vld_o", int'(cv_u), 0);
      check("R9 res_mem_vld_o", int'(mv_u), 0);
      check("R9 scan_idx_o", int'(sidx_u), 0);
   endtask

   task automatic t_membership(input logic [N-1:0] a, input logic [N-1:0] b);
      set_a = a; set_b = b;
      pulse_init();
      check("R4 vld low in idle", int'(mv_u), 0);
      pulse_exec();
      for (int i = 0; i < N; i++) begin
         qidx = IDXW'(i);
         #1;
         check("R1 union", int'(mem_u), int'(a[i] | b[i]));
         check("R2 intersection", int'(mem_i), int'(a[i] & b[i]));
         check("R3 difference", int'(mem_d), int'(a[i] & ~b[i]));
         check("R4 vld high", int'(mv_u), 1);
      end
      a_qv = 1'b0; #1;
      check("R4 vld follows a valid", int'(mv_u), 0);
      a_qv = 1'b1; b_qv = 1'b0; #1;
      check("R4 vld follows b valid", int'(mv_i), 0);
      b_qv = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_count(input logic [N-1:0] a, input logic [N-1:0] b);
      int cyc = 0;
      set_a = a; set_b = b;
      pulse_init();
      pulse_exec();
      while (!cv_u && cyc < 4 * N) begin
         @(negedge clk);
         cyc++;
      end
      check("R7 cycles to card_vld", cyc, N);
      check("R5 union card", int'(card_u), pop(a | b));
      check("R5 intersection card", int'(card_i), pop(a & b));
      check("R5 difference card", int'(card_d), pop(a & ~b));
   endtask

   task automatic t_stall();
      logic [IDXW-1:0] idx0;
      logic [CW-1:0] c0;
      set_a = 8'b1111_1111; set_b = 8'b0000_1111;
      pulse_init();
      pulse_exec();
      repeat (3) @(negedge clk);
      idx0 = sidx_u; c0 = card_u;
      a_sv = 1'b0;
      repeat (2) @(negedge clk);
      check("R6 index held (a stall)", int'(sidx_u), int'(idx0));
      check("R6 count held (a stall)", int'(card_u), int'(c0));
      a_sv = 1'b1; b_sv = 1'b0;
      repeat (3) @(negedge clk);
      check("R6 index held (b stall)", int'(sidx_u), int'(idx0));
      check("R6 count held (b stall)", int'(card_u), int'(c0));
      check("R6 not done while stalled", int'(cv_u), 0);
      b_sv = 1'b1;
      repeat (N + 2) @(negedge clk);
      check("R6 union card after stall", int'(card_u), 8);
      check("R6 difference card after stall", int'(card_d), 4);
      check("R6 done after stall", int'(cv_d), 1);
   endtask

   task automatic t_hold_init();
      set_a = 8'b0101_0011; set_b = 8'b0011_0110;
      pulse_init();
      pulse_exec();
      repeat (N + 1) @(negedge clk);
      check("R8 done", int'(cv_u), 1);
      set_a = 8'hFF; set_b = 8'hFF;
      pulse_exec();
      repeat (N + 1) @(negedge clk);
      check("R8 card held through exec", int'(card_u), pop(8'b0111_0111));
      check("R8 inter held", int'(card_i), pop(8'b0001_0010));
      check("R8 vld held", int'(cv_u), 1);
      init_i = 1'b1; exec_i = 1'b1;
      @(negedge clk);
      init_i = 1'b0; exec_i = 1'b0;
      check("R8 init clears card", int'(card_u), 0);
      check("R8 init clears vld", int'(cv_u), 0);
      check("R8 init clears idx", int'(sidx_u), 0);
      check("R8 init beats exec", int'(mv_u), 0);
      @(negedge clk);
      check("R8 stays idle", int'(sidx_u), 0);
   endtask

   initial begin
      #(5 * 200000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_membership(8'b1100_1010, 8'b1010_0110);
      t_count(8'b0000_0000, 8'b0000_0000);
      t_count(8'b1111_1111, 8'b1111_1111);
      t_count(8'b1111_1111, 8'b0000_0000);
      t_count(8'b1010_1010, 8'b0101_0101);
      t_count(8'b1001_1101, 8'b1100_0101);
      t_stall();
      t_hold_init();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule